// File: doc/BRIEF.md
# Supply-Loss Reset Control Register

This block is a single 32-bit control register and the logic behind it that converts supply brown-out events and low-frequency clock-loss events into a system reset request. Three brown-out detector levels come in: the I/O supply, the regulated supply and the core supply. A clock-loss detector level and an enable from a separate oscillator control register also come in. For each supply, one of two bits arms the reset path: a normal enable bit or an override bit. The override bits can be frozen by a lock that only a reset releases. Clock loss leads to a reset only when two independent enables are both set.

The register also shows a sticky flag that records an I/O-event wakeup from shutdown. Software cannot clear this flag. The reset request is registered. It stays high for a programmable minimum number of cycles after the last qualifying event, so that downstream reset logic always sees a pulse of usable width. Software accesses the register through a plain write strobe with write data, and reads it through a combinational read bus.

Top module: `supply_loss_rstctl`

## Requirements
- R1: After reset, `rdData` reads 0x000000E0: loss-enable bits 7 (I/O), 6 (regulated) and 5 (core) are 1, override bits 11 (I/O), 10 (regulated) and 9 (core) are 0, clock-loss enable bit 4 is 0, `wakeFlag` is 0 and `sysRstReq` is 0.
- R2: A brown-out level on supply k (`bodIn[2]`=I/O, `bodIn[1]`=regulated, `bodIn[0]`=core) while its loss-enable bit is 1 causes a reset request.
- R3: A brown-out on supply k whose override bit is 1 causes a reset request whatever the loss-enable bit holds. When both bits of that supply are 0, its brown-out is ignored.
- R4: A `clkLoss` level causes a reset request only when register bit 4 and `clkLossDetEn` are both 1.
- R5: `sysRstReq` goes high in the cycle after a cycle with a qualifying event. It stays high for exactly HOLD_CYCLES cycles after the last such cycle, and otherwise stays low.
- R6: A one-cycle `lockIn` pulse freezes bits 11:9 from the next cycle on, so that writes leave them unchanged. Bits 7:4 stay writable. Only reset releases the lock.
- R7: A `wakeIoPulse` sets bit 14 and `wakeFlag` at the next edge. The flag stays set until reset, and writes do not clear it.
- R8: Bits 31:15, 13:12, 8 and 3:0 always read 0, whatever value is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data |
| lockIn | input | 1 | Pulse that locks the override bits until reset |
| bodIn | input | 3 | Brown-out levels: [2] I/O, [1] regulated, [0] core |
| clkLoss | input | 1 | Low-frequency clock-loss level |
| clkLossDetEn | input | 1 | Clock-loss detection enable from the oscillator control |
| wakeIoPulse | input | 1 | One-cycle pulse: I/O-event wakeup from shutdown |
| sysRstReq | output | 1 | Registered system reset request |
| wakeFlag | output | 1 | Sticky wakeup-from-shutdown flag |

## Verification
The qualification logic is tried with three kinds of configuration:
- Only the normal enable set, which separates the enable path from the override path.
- Only the override set.
- Neither bit set, which shows that an unarmed supply is ignored.

Events are also applied on a mix of armed and unarmed supplies. Each clock-loss gate combination is tried with one of its two enables missing and then with both present. A single-event pulse measures the hold window exactly. Writes around the lock pulse and the wake pulse show which bits are frozen, which stay writable and which are sticky.

// File: rtl/slr_pkg.sv
package slr_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_SUP   = 3;
  localparam int BIT_WAKE  = 14;
  localparam int OVR_LSB   = 9;
  localparam int EN_LSB    = 5;
  localparam int BIT_CLKEN = 4;

  typedef struct packed {
    logic wrCommon;
    logic wrOvr;
    logic setWake;
  } slrStrobes_t;

  typedef struct packed {
    logic [NUM_SUP-1:0] lossEn;
    logic [NUM_SUP-1:0] ovr;
    logic               clkEn;
    logic               wake;
  } slrFields_t;
endpackage

// File: rtl/slr_ctrl.sv
module slr_ctrl
  import slr_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               lockIn,
  input  logic               wakeIoPulse,
  input  logic [NUM_SUP-1:0] bodIn,
  input  logic               clkLoss,
  input  logic               clkLossDetEn,
  input  slrFields_t         fields,
  output slrStrobes_t        strobes,
  output logic               sysRstReq
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic             lockQ;
  logic [CNT_W-1:0] holdCnt;
  logic [NUM_SUP-1:0] supHit;
  logic             clkHit;
  logic             evtHit;

  // Lock is sticky: only reset clears it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockQ <= 1'b0;
    else if (lockIn) lockQ <= 1'b1;
  end

  generate
    for (genvar k = 0; k < NUM_SUP; k++) begin : g_sup
      assign supHit[k] = bodIn[k] & (fields.lossEn[k] | fields.ovr[k]);
    end
  endgenerate

  assign clkHit = clkLoss & fields.clkEn & clkLossDetEn;
  assign evtHit = (|supHit) | clkHit;

  always_comb begin
    strobes.wrCommon = regWrEn;
    strobes.wrOvr    = regWrEn & ~lockQ;
    strobes.setWake  = wakeIoPulse;
  end

  // Minimum-width hold window, retriggered by every qualifying cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (evtHit) holdCnt <= CNT_W'(HOLD_CYCLES);
    else if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
  end

  assign sysRstReq = (holdCnt != '0);
endmodule

// File: rtl/slr_datapath.sv
module slr_datapath
  import slr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  slrStrobes_t      strobes,
  input  logic [REG_W-1:0] regWrData,
  output slrFields_t       fields,
  output logic [REG_W-1:0] rdData,
  output logic             wakeFlag
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fields.lossEn <= '1;
      fields.clkEn  <= 1'b0;
    end else if (strobes.wrCommon) begin
      fields.lossEn <= regWrData[EN_LSB +: NUM_SUP];
      fields.clkEn  <= regWrData[BIT_CLKEN];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fields.ovr <= '0;
    else if (strobes.wrOvr) fields.ovr <= regWrData[OVR_LSB +: NUM_SUP];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fields.wake <= 1'b0;
    else if (strobes.setWake) fields.wake <= 1'b1;
  end

  always_comb begin
    rdData = '0;
    rdData[BIT_WAKE]             = fields.wake;
    rdData[OVR_LSB +: NUM_SUP]   = fields.ovr;
    rdData[EN_LSB +: NUM_SUP]    = fields.lossEn;
    rdData[BIT_CLKEN]            = fields.clkEn;
  end

  assign wakeFlag = fields.wake;
endmodule

// File: rtl/supply_loss_rstctl.sv
module supply_loss_rstctl
  import slr_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] rdData,
  input  logic        lockIn,
  input  logic [2:0]  bodIn,
  input  logic        clkLoss,
  input  logic        clkLossDetEn,
  input  logic        wakeIoPulse,
  output logic        sysRstReq,
  output logic        wakeFlag
);
  slrStrobes_t strobes;
  slrFields_t  fields;

  slr_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .lockIn(lockIn),
    .wakeIoPulse(wakeIoPulse), .bodIn(bodIn), .clkLoss(clkLoss),
    .clkLossDetEn(clkLossDetEn), .fields(fields), .strobes(strobes),
    .sysRstReq(sysRstReq)
  );

  slr_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .fields(fields), .rdData(rdData), .wakeFlag(wakeFlag)
  );
endmodule

// File: rtl/slr_checker.sv
module slr_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] rdData,
  input logic        lockIn,
  input logic [2:0]  bodIn,
  input logic        clkLoss,
  input logic        clkLossDetEn,
  input logic        wakeIoPulse,
  input logic        sysRstReq,
  input logic        wakeFlag
);
  logic lockSeen;
  logic qual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lockSeen <= 1'b0;
    else if (lockIn) lockSeen <= 1'b1;
  end

  assign qual = |(bodIn & (rdData[7:5] | rdData[11:9])) |
                (clkLoss & clkLossDetEn & rdData[4]);

  AST_RO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & 32'hFFFF_B10F) == 32'h0); // R8
  AST_BOD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (|(bodIn & (rdData[7:5] | rdData[11:9]))) |=> sysRstReq); // R3
  AST_CLK_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (clkLoss && clkLossDetEn && rdData[4]) |=> sysRstReq); // R4
  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstReq) |-> $past(qual)); // R5
  AST_OVR_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    lockSeen |=> $stable(rdData[11:9])); // R6
  AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rstN)
    wakeIoPulse |=> wakeFlag); // R7
  AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wakeFlag |=> (wakeFlag && rdData[14])); // R7
endmodule

bind supply_loss_rstctl slr_checker chk_i (
  .clk(clk), .rstN(rstN), .rdData(rdData), .lockIn(lockIn), .bodIn(bodIn),
  .clkLoss(clkLoss), .clkLossDetEn(clkLossDetEn), .wakeIoPulse(wakeIoPulse),
  .sysRstReq(sysRstReq), .wakeFlag(wakeFlag)
);

// File: tb/supply_loss_rstctl_tb_top.sv
module supply_loss_rstctl_tb_top;
  localparam int HOLD = 8;
  localparam int NVEC = 10;
  // {en[2:0], ovr[2:0], clkEn, bod[2:0], clkLoss, detEn}
  localparam logic [11:0] VEC [NVEC] = '{
    12'b111_000_0_100_0_0,
    12'b000_000_0_111_0_0,
    12'b000_010_0_010_0_0,
    12'b000_010_0_101_0_0,
    12'b001_000_0_001_0_0,
    12'b000_000_1_000_1_0,
    12'b000_000_0_000_1_1,
    12'b000_000_1_000_1_1,
    12'b110_001_0_001_0_0,
    12'b000_000_0_000_1_1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] rdData;
  logic lockIn = 1'b0;
  logic [2:0] bodIn = '0;
  logic clkLoss = 1'b0;
  logic clkLossDetEn = 1'b0;
  logic wakeIoPulse = 1'b0;
  logic sysRstReq;
  logic wakeFlag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  supply_loss_rstctl #(.HOLD_CYCLES(HOLD)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .rdData(rdData), .lockIn(lockIn), .bodIn(bodIn), .clkLoss(clkLoss),
    .clkLossDetEn(clkLossDetEn), .wakeIoPulse(wakeIoPulse),
    .sysRstReq(sysRstReq), .wakeFlag(wakeFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] cfgWord(logic [2:0] en, logic [2:0] ovr, logic ce);
    return (32'(en) << 5) | (32'(ovr) << 9) | (32'(ce) << 4);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 32'h0000_00E0);
    check("R1 sysRstReq", 32'(sysRstReq), 32'h0);
    check("R1 wakeFlag", 32'(wakeFlag), 32'h0);

    // R2 R3 R4 table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [2:0] en, ovr, bod;
      logic ce, cl, det, exp;
      {en, ovr, ce, bod, cl, det} = VEC[i];
      exp = (|(bod & (en | ovr))) | (cl & ce & det);
      wr(cfgWord(en, ovr, ce));
      check("R2 R3 R4 cfg readback", rdData, cfgWord(en, ovr, ce));
      bodIn = bod; clkLoss = cl; clkLossDetEn = det;
      @(negedge clk);
      bodIn = '0; clkLoss = 1'b0; clkLossDetEn = 1'b0;
      check("R2 R3 R4 request", 32'(sysRstReq), 32'(exp));
      repeat (HOLD + 2) @(negedge clk);
      check("R5 drained", 32'(sysRstReq), 32'h0);
    end

    // R5 exact hold width after a single event
    wr(cfgWord(3'b111, 3'b000, 1'b0));
    check("R5 idle before", 32'(sysRstReq), 32'h0);
    bodIn = 3'b001;
    @(negedge clk);
    bodIn = '0;
    begin
      int highs = 0;
      for (int c = 0; c < HOLD + 3; c++) begin
        if (sysRstReq) highs++;
        @(negedge clk);
      end
      check("R5 hold cycles", 32'(highs), 32'(HOLD));
    end
    // R5 retrigger extends window
    bodIn = 3'b100;
    @(negedge clk);
    bodIn = '0;
    repeat (HOLD - 2) @(negedge clk);
    bodIn = 3'b100;
    @(negedge clk);
    bodIn = '0;
    repeat (HOLD - 1) @(negedge clk);
    check("R5 retrigger still high", 32'(sysRstReq), 32'h1);
    @(negedge clk);
    check("R5 retrigger ends", 32'(sysRstReq), 32'h0);

    // R8 read-only bits ignore writes
    wr(32'hFFFF_FFFF);
    check("R8 ones write", rdData, 32'h0000_0EF0);

    // R7 wake flag
    check("R7 wake clear before", 32'(wakeFlag), 32'h0);
    @(negedge clk);
    wakeIoPulse = 1'b1;
    @(negedge clk);
    wakeIoPulse = 1'b0;
    check("R7 wake set", rdData & 32'h4000, 32'h4000);
    wr(32'h0);
    check("R7 wake after write", rdData, 32'h0000_4000);
    check("R7 wakeFlag port", 32'(wakeFlag), 32'h1);

    // R6 lock
    wr(cfgWord(3'b000, 3'b101, 1'b0));
    @(negedge clk);
    lockIn = 1'b1;
    @(negedge clk);
    lockIn = 1'b0;
    wr(cfgWord(3'b111, 3'b010, 1'b1));
    check("R6 ovr frozen, others written", rdData, 32'h4000 | cfgWord(3'b111, 3'b101, 1'b1));
    wr(32'h0);
    check("R6 ovr frozen on clear", rdData, 32'h4000 | cfgWord(3'b000, 3'b101, 1'b0));
    bodIn = 3'b010;
    @(negedge clk);
    bodIn = '0;
    check("R3 unarmed regulated ignored", 32'(sysRstReq), 32'h0);
    bodIn = 3'b100;
    @(negedge clk);
    bodIn = '0;
    check("R3 locked override still arms", 32'(sysRstReq), 32'h1);
    repeat (HOLD + 1) @(negedge clk);
    doReset();
    check("R1 R7 reset clears wake", rdData, 32'h0000_00E0);
    wr(cfgWord(3'b111, 3'b010, 1'b0));
    check("R6 lock released by reset", rdData, cfgWord(3'b111, 3'b010, 1'b0));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule